// File: doc/BRIEF.md
# E1 Spare-Bit Data Link Inserter

This block places a low-rate serial data link into the national-use spare bits of an outgoing E1 stream. A timing generator presents each bit of the transmit stream with a one-cycle strobe. With each strobe it also gives the bit's position: whether the frame is one that carries no alignment word, the timeslot number, and the bit number within the slot. The block passes most bits through untouched. In bits 4 to 8 of timeslot 0 of non-alignment frames, it can substitute data from an external link source.

A 5-bit mask chooses which of the five spare positions (Sa4 to Sa8) carry link data, and any combination is allowed. A global enable switches the function on or off. For every selected position, the block raises a demand pulse one bit period ahead of that position. The link source answers the pulse by presenting one bit, and the block captures that bit on the strobe of the spare position itself. Each selected position therefore adds 4 kbit/s to the link rate, so the rate ranges from 4 to 20 kbit/s. Within a frame the positions are filled in ascending order, from Sa4 to Sa8.

Top module: `e1_sa_inserter`

## Requirements
- R1: While reset is asserted, and until the first strobe after it, both `tx_bit_o` and `link_req_o` are 0.
- R2: A strobed bit that is not in bits 4 to 8 of timeslot 0 of a frame with `frame_odd_i`=1 appears unchanged on `tx_bit_o` one clock after its strobe.
- R3: Bit numbers follow `bit_idx_i` = 0 for bit 1 up to 7 for bit 8, and mask bit k selects position Sa(4+k), which is `bit_idx_i` = 3+k. When the function is enabled and the selected position is strobed, `tx_bit_o` shows the `link_data_i` value sampled on that strobe, one clock after it.
- R4: A spare position whose mask bit is 0 passes the input bit through unchanged.
- R5: With `link_en_i`=0, every bit passes through and `link_req_o` stays 0.
- R6: `link_req_o` is 1 for exactly the bit period before each selected spare position, so each non-alignment frame gives popcount(mask) demand pulses. It is 0 in every other bit period.
- R7: Link bits are consumed in the order they are supplied, and they fill the selected positions in ascending order from Sa4 to Sa8.
- R8: Between strobes, `tx_bit_o` and `link_req_o` hold their values, whatever `tx_bit_i` and `link_data_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb_i | input | 1 | One-cycle strobe marking a new transmit bit |
| frame_odd_i | input | 1 | 1 when the current frame carries no alignment word |
| slot_idx_i | input | 5 | Timeslot number 0 to 31 |
| bit_idx_i | input | 3 | Bit number in the slot, 0 = bit 1 |
| tx_bit_i | input | 1 | Incoming transmit bit |
| sa_mask_i | input | 5 | Bit k selects position Sa(4+k) for the link |
| link_en_i | input | 1 | Global enable of the insertion |
| link_data_i | input | 1 | Link bit from the external source |
| link_req_o | output | 1 | Demand pulse asking the source for the next link bit |
| tx_bit_o | output | 1 | Outgoing transmit bit, one clock behind its strobe |

## Verification
A wrong position decode or a wrong mask bit shows up on `tx_bit_o` one clock after the affected strobe. In that case a random input bit or an unrequested link value takes the place of the expected bit. A demand register that is off by one bit period shows at once on `link_req_o`, and on the first selected position it also causes the wrong link bit to be captured. From that point, every later inserted bit in the reference link pattern is out of step. Lost hold behaviour changes an output in the idle cycle between two strobes.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int E1_SLOTS       = 32;
  localparam int E1_SLOT_BITS   = 8;
  localparam int E1_SPARE_COUNT = 5;
  localparam int E1_SPARE_FIRST = 3;  // bit index of the first spare bit (bit 4)
  localparam int E1_TS_W        = $clog2(E1_SLOTS);
  localparam int E1_BIT_W       = $clog2(E1_SLOT_BITS);

  typedef struct packed {
    logic                odd;
    logic [E1_TS_W-1:0]  slot;
    logic [E1_BIT_W-1:0] bidx;
  } e1sa_pos_t;
endpackage

// File: rtl/e1sa_rst_sync.sv
module e1sa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/e1sa_slot_decode.sv
module e1sa_slot_decode
  import e1sa_pkg::*;
#(
  parameter int SA_COUNT = E1_SPARE_COUNT,
  parameter int SA_FIRST = E1_SPARE_FIRST
) (
  input  e1sa_pos_t           pos,
  input  logic [SA_COUNT-1:0] mask,
  input  logic                enable,
  output logic [SA_COUNT-1:0] cur_sel,
  output logic [SA_COUNT-1:0] nxt_sel
);
  logic slot_zero_odd;

  assign slot_zero_odd = enable && pos.odd && (pos.slot == '0);

  // One decode per spare position: is this bit it, or is the next bit it?
  for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
    assign cur_sel[k] = slot_zero_odd && mask[k] &&
                        (pos.bidx == E1_BIT_W'(SA_FIRST + k));
    assign nxt_sel[k] = slot_zero_odd && mask[k] &&
                        (pos.bidx == E1_BIT_W'(SA_FIRST + k - 1));
  end
endmodule

// File: rtl/e1sa_demand_gen.sv
module e1sa_demand_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic next_is_sa,
  output logic req
);
  logic req_q;
  logic req_d;

  always_comb begin
    req_d = req_q;
    if (stb) req_d = next_is_sa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/e1sa_bit_mux.sv
module e1sa_bit_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic take_link,
  input  logic line_bit,
  input  logic link_bit,
  output logic out_bit
);
  logic out_q;
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (stb) out_d = take_link ? link_bit : line_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_bit = out_q;
endmodule

// File: rtl/e1_sa_inserter.sv
module e1_sa_inserter
  import e1sa_pkg::*;
#(
  parameter int SA_COUNT = E1_SPARE_COUNT,
  parameter int SA_FIRST = E1_SPARE_FIRST
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb_i,
  input  logic                frame_odd_i,
  input  logic [E1_TS_W-1:0]  slot_idx_i,
  input  logic [E1_BIT_W-1:0] bit_idx_i,
  input  logic                tx_bit_i,
  input  logic [SA_COUNT-1:0] sa_mask_i,
  input  logic                link_en_i,
  input  logic                link_data_i,
  output logic                link_req_o,
  output logic                tx_bit_o
);
  logic                core_rst_n;
  e1sa_pos_t           pos;
  logic [SA_COUNT-1:0] cur_sel;
  logic [SA_COUNT-1:0] nxt_sel;

  assign pos = '{odd: frame_odd_i, slot: slot_idx_i, bidx: bit_idx_i};

  e1sa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  e1sa_slot_decode #(.SA_COUNT(SA_COUNT), .SA_FIRST(SA_FIRST)) u_dec (
    .pos     (pos),
    .mask    (sa_mask_i),
    .enable  (link_en_i),
    .cur_sel (cur_sel),
    .nxt_sel (nxt_sel)
  );

  e1sa_demand_gen u_dem (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .stb        (bit_stb_i),
    .next_is_sa (|nxt_sel),
    .req        (link_req_o)
  );

  e1sa_bit_mux u_mux (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .stb       (bit_stb_i),
    .take_link (|cur_sel),
    .line_bit  (tx_bit_i),
    .link_bit  (link_data_i),
    .out_bit   (tx_bit_o)
  );
endmodule

// File: rtl/e1_sa_inserter_chk.sv
module e1_sa_inserter_chk #(
  parameter int SA_COUNT = 5,
  parameter int SA_FIRST = 3,
  parameter int TS_W     = 5,
  parameter int BIT_W    = 3
) (
  input logic                clk,
  input logic                core_rst_n,
  input logic                bit_stb_i,
  input logic                frame_odd_i,
  input logic [TS_W-1:0]     slot_idx_i,
  input logic [BIT_W-1:0]    bit_idx_i,
  input logic                tx_bit_i,
  input logic [SA_COUNT-1:0] sa_mask_i,
  input logic                link_en_i,
  input logic                link_data_i,
  input logic                link_req_o,
  input logic                tx_bit_o
);
  logic in_spare;   // position is any spare bit of a non-alignment frame
  logic chosen;     // position is a spare bit selected for the link

  always_comb begin
    in_spare = 1'b0;
    chosen   = 1'b0;
    for (int k = 0; k < SA_COUNT; k++) begin
      if (int'(bit_idx_i) == SA_FIRST + k) begin
        in_spare = frame_odd_i && (slot_idx_i == '0);
        chosen   = in_spare && link_en_i && sa_mask_i[k];
      end
    end
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_stb_i && !in_spare |=> tx_bit_o == $past(tx_bit_i));

  a_r3_link_inserted: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_stb_i && chosen |=> tx_bit_o == $past(link_data_i));

  a_r4_masked_pass: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_stb_i && in_spare && !chosen |=> tx_bit_o == $past(tx_bit_i));

  a_r5_no_demand_off: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_stb_i && !link_en_i |=> !link_req_o);

  a_r6_demand_precedes_spare: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_stb_i && link_req_o |-> in_spare);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!core_rst_n)
    !bit_stb_i |=> $stable(tx_bit_o) && $stable(link_req_o));
endmodule

bind e1_sa_inserter e1_sa_inserter_chk #(
  .SA_COUNT (SA_COUNT),
  .SA_FIRST (SA_FIRST),
  .TS_W     (e1sa_pkg::E1_TS_W),
  .BIT_W    (e1sa_pkg::E1_BIT_W)
) u_chk (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .bit_stb_i   (bit_stb_i),
  .frame_odd_i (frame_odd_i),
  .slot_idx_i  (slot_idx_i),
  .bit_idx_i   (bit_idx_i),
  .tx_bit_i    (tx_bit_i),
  .sa_mask_i   (sa_mask_i),
  .link_en_i   (link_en_i),
  .link_data_i (link_data_i),
  .link_req_o  (link_req_o),
  .tx_bit_o    (tx_bit_o)
);

// File: tb/e1_sa_inserter_tb.sv
module e1_sa_inserter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_stb_i;
  logic       frame_odd_i;
  logic [4:0] slot_idx_i;
  logic [2:0] bit_idx_i;
  logic       tx_bit_i;
  logic [4:0] sa_mask_i;
  logic       link_en_i;
  logic       link_data_i;
  logic       link_req_o;
  logic       tx_bit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  localparam logic [15:0] LINK_PAT = 16'hB4E1;
  int link_idx = 0;

  always #4 clk = ~clk;

  e1_sa_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb_i(bit_stb_i), .frame_odd_i(frame_odd_i),
    .slot_idx_i(slot_idx_i), .bit_idx_i(bit_idx_i), .tx_bit_i(tx_bit_i),
    .sa_mask_i(sa_mask_i), .link_en_i(link_en_i), .link_data_i(link_data_i),
    .link_req_o(link_req_o), .tx_bit_o(tx_bit_o)
  );

  function automatic logic rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives nfr frames (starting with an alignment frame) bit by bit and checks every output.
  task automatic run_frames(input logic [4:0] mask, input logic en, input int nfr,
                            output int pulses, output int inserted);
    pulses = 0; inserted = 0;
    sa_mask_i = mask; link_en_i = en;
    for (int f = 0; f < nfr; f++) begin
      for (int ts = 0; ts < 32; ts++) begin
        for (int b = 0; b < 8; b++) begin
          logic seen, presented, ins, in_sa, exp_out, exp_req;
          string tag;
          seen = link_req_o;
          if (seen) pulses++;
          bit_stb_i = 1'b1; frame_odd_i = f[0];
          slot_idx_i = 5'(ts); bit_idx_i = 3'(b);
          tx_bit_i = rnd_bit();
          if (seen) begin
            presented = LINK_PAT[link_idx % 16];
            link_idx++;
          end else presented = rnd_bit();
          link_data_i = presented;
          in_sa   = f[0] && ts == 0 && b >= 3;
          ins     = en && in_sa && mask[b-3];
          exp_out = ins ? presented : tx_bit_i;
          exp_req = en && f[0] && ts == 0 && b >= 2 && b <= 6 && mask[b-2];
          if (ins) inserted++;
          tag = ins ? "R3" : (!en ? "R5" : (in_sa ? "R4" : "R2"));
          @(negedge clk);
          chk(tag, "tx_bit_o", tx_bit_o, exp_out);
          chk(en ? "R6" : "R5", "link_req_o", link_req_o, exp_req);
          bit_stb_i = 1'b0; tx_bit_i = rnd_bit(); link_data_i = rnd_bit();
          @(negedge clk);
          chk("R8", "tx_bit_o hold", tx_bit_o, exp_out);
          chk("R8", "link_req_o hold", link_req_o, exp_req);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_stb_i = 1'b0; frame_odd_i = 1'b0; slot_idx_i = '0;
    bit_idx_i = '0; tx_bit_i = 1'b1; sa_mask_i = 5'h1F; link_en_i = 1'b1;
    link_data_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "tx_bit_o in reset", tx_bit_o, 0);
    chk("R1", "link_req_o in reset", link_req_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "tx_bit_o after release", tx_bit_o, 0);
    chk("R1", "link_req_o after release", link_req_o, 0);
  endtask

  task automatic t_all_five();
    int p, n;
    link_idx = 0;
    run_frames(5'b11111, 1'b1, 4, p, n);
    chk("R6", "demand pulses all five", p, 10);
    chk("R7", "link bits consumed in order", n, 10);
    chk("R7", "link index after two odd frames", link_idx, 10);
  endtask

  task automatic t_none();
    int p, n;
    run_frames(5'b00000, 1'b1, 4, p, n);
    chk("R6", "demand pulses with empty mask", p, 0);
    chk("R4", "inserted with empty mask", n, 0);
  endtask

  task automatic t_sparse();
    int p, n;
    run_frames(5'b10101, 1'b1, 4, p, n);
    chk("R6", "demand pulses Sa4 Sa6 Sa8", p, 6);
    chk("R7", "inserted Sa4 Sa6 Sa8", n, 6);
  endtask

  task automatic t_last_only();
    int p, n;
    run_frames(5'b10000, 1'b1, 2, p, n);
    chk("R6", "demand pulses Sa8 only", p, 1);
  endtask

  task automatic t_first_two();
    int p, n;
    run_frames(5'b00011, 1'b1, 2, p, n);
    chk("R6", "demand pulses Sa4 Sa5", p, 2);
  endtask

  task automatic t_disabled();
    int p, n;
    run_frames(5'b11111, 1'b0, 4, p, n);
    chk("R5", "demand pulses when disabled", p, 0);
  endtask

  initial begin
    t_reset();
    t_all_five();
    t_none();
    t_sparse();
    t_last_only();
    t_first_two();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule